// File: doc/BRIEF.md
# Configuration Access Filter and Router

This block sits in front of a configuration request engine. Each cycle it may accept one configuration read or write, given as bus, device, function, byte offset, access size, a write flag and write data. It classifies the request against a stored root bus number and the current link state. Then it does one of three things: it suppresses the request, it passes it to the local memory-mapped register space of the root port, or it forwards it as a configuration request for the TLP engine, with a dword-aligned offset, byte enables and lane-placed write data.

Suppressed requests finish at once with a done pulse. A suppressed read returns all ones, sized to the access. The stored root bus number comes from a parameter at reset. It then follows writes to the root port's primary bus number register, so enumeration software can renumber the hierarchy without touching the block. Every decision is registered and shows up on the outputs one clock after the request is presented.

Top module: `cfg_access_router`

## Requirements
- R1: A request whose bus equals the stored root bus, with device 0 and not hidden, is issued on the local port one cycle later, carrying its unmodified offset, size, write flag and write data.
- R2: A root-bus request to device 0, function 0, offset 0x10 is hidden. It produces only a done pulse: a read returns all ones and a write goes nowhere.
- R3: A request to any bus other than the root bus, made while the link-active bit is clear, is suppressed (done pulse only).
- R4: A request with a nonzero device number, on the root bus or on the bus numbered root+1 (modulo 256), is suppressed (done pulse only).
- R5: Any other valid request is forwarded on the TLP port with offset[11:2] kept and offset[1:0] cleared. Byte enables are 4'b0001<<offset[1:0] for size 0 (byte), 4'b0011<<offset[1:0] for size 1 (half-word), and 4'b1111 for sizes 2 and 3 (word). Enable bits shifted above bit 3 are dropped.
- R6: Forwarded write data is the request data shifted left by 8*offset[1:0] bits, truncated to 32 bits.
- R7: A suppressed read returns 0x000000FF for size 0, 0x0000FFFF for size 1, and 0xFFFFFFFF for sizes 2 and 3. A suppressed write returns 0.
- R8: A write issued on the local port to offset 0x18 loads write data bits [7:0] into the stored root bus number. The new value applies from the next request on.
- R9: One cycle after each accepted request exactly one of loc_valid, tlp_valid and sup_done is high. With no request, all three are low.
- R10: After reset the stored root bus number equals ROOT_BUS_RESET and no output strobe is high.
- R11: Link activity is read from bit 13 of link_status alone. The other bits have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_wdata | input | 32 | Write data, right-justified |
| link_status | input | 16 | Link status word; bit 13 = link active |
| loc_valid | output | 1 | Local register access strobe |
| loc_write | output | 1 | Local access is a write |
| loc_off | output | 12 | Local byte offset |
| loc_size | output | 2 | Local access size |
| loc_wdata | output | 32 | Local write data |
| tlp_valid | output | 1 | Forwarded request strobe |
| tlp_write | output | 1 | Forwarded request is a write |
| tlp_bus | output | 8 | Forwarded bus |
| tlp_dev | output | 5 | Forwarded device |
| tlp_fn | output | 3 | Forwarded function |
| tlp_dw_off | output | 12 | Dword-aligned offset |
| tlp_be | output | 4 | Byte enables |
| tlp_wdata | output | 32 | Lane-placed write data |
| sup_done | output | 1 | Suppressed request completed |
| sup_rdata | output | 32 | Read result for suppressed request |

## Verification
The directed cases go after the corners where the decision hinges on one field. BAR0 on function 1 or device 0 at offset 0x14 must still route. A design that compares only the offset would hide too much. Snooping is checked by a write to offset 0x18 followed at once by a request on the new bus. A design that updates late, or that snoops forwarded writes too, routes that request the wrong way. Other cases cover link_status with every bit set except bit 13, the root+1 wrap at bus 255, and a half-word at offset 3. A wrong link bit, a missing wrap or an unmasked byte enable each shows up as a misrouted request or a bad tlp_be. Random traffic that renumbers the root bus is checked against a bench model.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  typedef enum logic [2:0] {
    RT_IDLE   = 3'd0,
    RT_HIDE   = 3'd1,
    RT_NOLINK = 3'd2,
    RT_BADDEV = 3'd3,
    RT_LOCAL  = 3'd4,
    RT_TLP    = 3'd5
  } route_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  function automatic logic is_suppressed(route_e r);
    return (r == RT_HIDE) || (r == RT_NOLINK) || (r == RT_BADDEV);
  endfunction

endpackage

// File: rtl/cfg_classify.sv
module cfg_classify
  import cfg_router_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int OFF_W   = 12,
  parameter int BAR_OFF = 'h10
) (
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic [OFF_W-1:0] off,
  input  logic [BUS_W-1:0] root_bus,
  input  logic             link_up,
  output route_e           route
);
  localparam logic [OFF_W-1:0] BAR_O = OFF_W'(BAR_OFF);

  logic [BUS_W-1:0] below_bus;
  logic             on_root;
  logic             on_below;
  logic             hide_hit;

  always_comb begin
    below_bus = root_bus + BUS_W'(1);
    on_root   = (bus == root_bus);
    on_below  = (bus == below_bus);
    hide_hit  = on_root && (dev == '0) && (fn == '0) && (off == BAR_O);
    if (hide_hit)
      route = RT_HIDE;
    else if (!on_root && !link_up)
      route = RT_NOLINK;
    else if ((on_root || on_below) && (dev != '0))
      route = RT_BADDEV;
    else if (on_root)
      route = RT_LOCAL;
    else
      route = RT_TLP;
  end
endmodule

// File: rtl/cfg_lane_pack.sv
module cfg_lane_pack
  import cfg_router_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        lane,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [3:0]        be,
  output logic [DATA_W-1:0] lane_wdata,
  output logic [DATA_W-1:0] ones_rdata
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] ones_mask;

  always_comb begin
    case (size)
      SZ_BYTE: be = 4'b0001 << lane;
      SZ_HALF: be = 4'b0011 << lane;
      default: be = 4'b1111;
    endcase
    case (size)
      SZ_BYTE: ones_mask = LANES'(1);
      SZ_HALF: ones_mask = LANES'(3);
      default: ones_mask = '1;
    endcase
    lane_wdata = wdata << {lane, 3'b000};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_ones
    assign ones_rdata[g*8 +: 8] = {8{ones_mask[g]}};
  end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_router_pkg::*;
#(
  parameter int BUS_W          = 8,
  parameter int DEV_W          = 5,
  parameter int FN_W           = 3,
  parameter int OFF_W          = 12,
  parameter int DATA_W         = 32,
  parameter int LSTAT_W        = 16,
  parameter int LINK_BIT       = 13,
  parameter int BAR_OFF        = 'h10,
  parameter int PRI_BUS_OFF    = 'h18,
  parameter int ROOT_BUS_RESET = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [FN_W-1:0]    req_fn,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LSTAT_W-1:0] link_status,
  output logic               loc_valid,
  output logic               loc_write,
  output logic [OFF_W-1:0]   loc_off,
  output logic [1:0]         loc_size,
  output logic [DATA_W-1:0]  loc_wdata,
  output logic               tlp_valid,
  output logic               tlp_write,
  output logic [BUS_W-1:0]   tlp_bus,
  output logic [DEV_W-1:0]   tlp_dev,
  output logic [FN_W-1:0]    tlp_fn,
  output logic [OFF_W-1:0]   tlp_dw_off,
  output logic [3:0]         tlp_be,
  output logic [DATA_W-1:0]  tlp_wdata,
  output logic               sup_done,
  output logic [DATA_W-1:0]  sup_rdata
);
  localparam logic [OFF_W-1:0] PRI_O    = OFF_W'(PRI_BUS_OFF);
  localparam logic [BUS_W-1:0] ROOT_RST = BUS_W'(ROOT_BUS_RESET);

  route_e            route;
  logic              link_up;
  logic [3:0]        be_c;
  logic [DATA_W-1:0] lane_wdata_c;
  logic [DATA_W-1:0] ones_c;

  logic [BUS_W-1:0]  root_q, root_d;
  logic              loc_v_d, tlp_v_d, sup_v_d;
  logic              loc_en, tlp_en, sup_en;
  logic [DATA_W-1:0] sup_rdata_d;

  assign link_up = link_status[LINK_BIT];

  cfg_classify #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .OFF_W(OFF_W), .BAR_OFF(BAR_OFF)
  ) u_classify (
    .bus(req_bus), .dev(req_dev), .fn(req_fn), .off(req_off),
    .root_bus(root_q), .link_up(link_up), .route(route)
  );

  cfg_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .lane(req_off[1:0]), .size(req_size), .wdata(req_wdata),
    .be(be_c), .lane_wdata(lane_wdata_c), .ones_rdata(ones_c)
  );

  // next-state
  always_comb begin
    loc_v_d     = req_valid && (route == RT_LOCAL);
    tlp_v_d     = req_valid && (route == RT_TLP);
    sup_v_d     = req_valid && is_suppressed(route);
    loc_en      = loc_v_d;
    tlp_en      = tlp_v_d;
    sup_en      = sup_v_d;
    sup_rdata_d = req_write ? '0 : ones_c;
    root_d      = root_q;
    if (loc_v_d && req_write && (req_off == PRI_O))
      root_d = req_wdata[BUS_W-1:0];
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q    <= ROOT_RST;
      loc_valid <= 1'b0;
      tlp_valid <= 1'b0;
      sup_done  <= 1'b0;
    end else begin
      root_q    <= root_d;
      loc_valid <= loc_v_d;
      tlp_valid <= tlp_v_d;
      sup_done  <= sup_v_d;
    end
  end

  // data registers, enabled per path
  always_ff @(posedge clk) begin
    if (loc_en) begin
      loc_write <= req_write;
      loc_off   <= req_off;
      loc_size  <= req_size;
      loc_wdata <= req_wdata;
    end
    if (tlp_en) begin
      tlp_write  <= req_write;
      tlp_bus    <= req_bus;
      tlp_dev    <= req_dev;
      tlp_fn     <= req_fn;
      tlp_dw_off <= {req_off[OFF_W-1:2], 2'b00};
      tlp_be     <= be_c;
      tlp_wdata  <= lane_wdata_c;
    end
    if (sup_en)
      sup_rdata <= sup_rdata_d;
  end
endmodule

// File: rtl/cfg_access_router_chk.sv
module cfg_access_router_chk #(
  parameter int BUS_W   = 8,
  parameter int OFF_W   = 12,
  parameter int LSTAT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [BUS_W-1:0]   req_bus,
  input logic [LSTAT_W-1:0] link_status,
  input logic [BUS_W-1:0]   root_q,
  input logic               loc_valid,
  input logic               loc_write,
  input logic               tlp_valid,
  input logic [OFF_W-1:0]   tlp_dw_off,
  input logic [3:0]         tlp_be,
  input logic               sup_done
);
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({loc_valid, tlp_valid, sup_done}) <= 1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(loc_valid || tlp_valid || sup_done));

  // R9
  req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (loc_valid || tlp_valid || sup_done));

  // R5
  dw_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlp_valid |-> (tlp_dw_off[1:0] == 2'b00 && tlp_be != 4'b0000));

  // R3
  nolink_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bus != root_q && !link_status[13]) |=> !(loc_valid || tlp_valid));

  // R8
  root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(root_q));

  // R1
  local_on_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bus != root_q) |=> !loc_valid);
endmodule

bind cfg_access_router cfg_access_router_chk #(
  .BUS_W(BUS_W), .OFF_W(OFF_W), .LSTAT_W(LSTAT_W)
) u_chk (.*);

// File: tb/tb_cfg_access_router.sv
module tb_cfg_access_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [11:0] req_off;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [15:0] link_status;
  logic        loc_valid, loc_write, tlp_valid, tlp_write, sup_done;
  logic [11:0] loc_off, tlp_dw_off;
  logic [1:0]  loc_size;
  logic [31:0] loc_wdata, tlp_wdata, sup_rdata;
  logic [7:0]  tlp_bus;
  logic [4:0]  tlp_dev;
  logic [2:0]  tlp_fn;
  logic [3:0]  tlp_be;

  int total = 0;
  int bad = 0;
  bit summary_done = 0;
  logic [7:0] m_root;

  always #5 clk = ~clk;

  cfg_access_router #(.ROOT_BUS_RESET(0)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // 0 suppress, 1 local, 2 tlp ; tag names the rule that decided
  function automatic int exp_class(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                                   input logic [11:0] o, input logic [15:0] ls, output string tag);
    bit root = (b == m_root);
    bit below = (b == 8'(m_root + 8'd1));
    if (root && d == 0 && f == 0 && o == 12'h010) begin tag = "R2"; return 0; end
    if (!root && !ls[13]) begin tag = "R3"; return 0; end
    if ((root || below) && d != 0) begin tag = "R4"; return 0; end
    if (root) begin tag = "R1"; return 1; end
    tag = "R5"; return 2;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] ln);
    if (sz == 2'd0) return 4'(4'b0001 << ln);
    if (sz == 2'd1) return 4'(4'b0011 << ln);
    return 4'hF;
  endfunction

  function automatic logic [31:0] exp_ones(input logic [1:0] sz);
    if (sz == 2'd0) return 32'h0000_00FF;
    if (sz == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic send(input bit w, input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                      input logic [11:0] o, input logic [1:0] sz, input logic [31:0] wd,
                      input logic [15:0] ls);
    string tag;
    int cls;
    @(negedge clk);
    req_valid = 1; req_write = w; req_bus = b; req_dev = d; req_fn = f;
    req_off = o; req_size = sz; req_wdata = wd; link_status = ls;
    cls = exp_class(b, d, f, o, ls, tag);
    @(posedge clk); #2;
    req_valid = 0;
    chk(sup_done == (cls == 0) && loc_valid == (cls == 1) && tlp_valid == (cls == 2),
        tag, {29'd0, sup_done, loc_valid, tlp_valid},
        {29'd0, cls == 0, cls == 1, cls == 2});
    if (cls == 0)
      chk(sup_rdata == (w ? 32'd0 : exp_ones(sz)), "R7", sup_rdata, w ? 32'd0 : exp_ones(sz));
    if (cls == 1)
      chk(loc_off == o && loc_size == sz && loc_write == w && (!w || loc_wdata == wd),
          "R1", {loc_write, 6'd0, loc_size, 11'd0, loc_off}, {w, 6'd0, sz, 11'd0, o});
    if (cls == 2) begin
      chk(tlp_dw_off == {o[11:2], 2'b00} && tlp_be == exp_be(sz, o[1:0]) &&
          tlp_bus == b && tlp_dev == d && tlp_fn == f && tlp_write == w,
          "R5", {16'd0, tlp_be, tlp_dw_off}, {16'd0, exp_be(sz, o[1:0]), o[11:2], 2'b00});
      if (w)
        chk(tlp_wdata == 32'(wd << (8 * o[1:0])), "R6", tlp_wdata, 32'(wd << (8 * o[1:0])));
    end
    if (cls == 1 && w && o == 12'h018) m_root = wd[7:0];
  endtask

  task automatic idle_check;
    @(negedge clk);
    req_valid = 0;
    @(posedge clk); #2;
    chk(!loc_valid && !tlp_valid && !sup_done, "R9", {loc_valid, tlp_valid, sup_done}, 0);
  endtask

  initial begin
    #2_000_000;
    if (!summary_done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0; req_fn = 0;
    req_off = 0; req_size = 0; req_wdata = 0; link_status = 16'h2000;
    m_root = 8'd0;
    repeat (3) @(posedge clk);
    #2;
    chk(!loc_valid && !tlp_valid && !sup_done, "R10", {loc_valid, tlp_valid, sup_done}, 0);
    @(negedge clk); rst_n = 1;
    // R10: root bus is 0 after reset, so bus 0 dev 0 goes local
    send(0, 8'd0, 5'd0, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    idle_check();
    // R2 hide read/write, and near misses that must route
    send(0, 8'd0, 5'd0, 3'd0, 12'h010, 2'd0, 0, 16'h2000);
    send(0, 8'd0, 5'd0, 3'd0, 12'h010, 2'd1, 0, 16'h2000);
    send(1, 8'd0, 5'd0, 3'd0, 12'h010, 2'd2, 32'h1234_5678, 16'h2000);
    send(0, 8'd0, 5'd0, 3'd1, 12'h010, 2'd2, 0, 16'h2000);
    send(0, 8'd0, 5'd0, 3'd0, 12'h014, 2'd2, 0, 16'h2000);
    // R3 / R11: link bit clear with others set, and only bit 13 set
    send(0, 8'd5, 5'd0, 3'd0, 12'h000, 2'd2, 0, 16'hDFFF);
    send(1, 8'd5, 5'd0, 3'd0, 12'h004, 2'd1, 32'hAB, 16'hDFFF);
    send(0, 8'd5, 5'd0, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    send(0, 8'd0, 5'd0, 3'd0, 12'h008, 2'd2, 0, 16'h0000);
    // R4
    send(0, 8'd0, 5'd1, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    send(0, 8'd1, 5'd3, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    send(0, 8'd2, 5'd3, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    // R5 / R6 lane corners
    send(1, 8'd1, 5'd0, 3'd2, 12'h103, 2'd1, 32'hBEEF, 16'h2000);
    send(1, 8'd1, 5'd0, 3'd0, 12'h102, 2'd0, 32'h5A, 16'h2000);
    send(0, 8'd1, 5'd0, 3'd0, 12'h0FF, 2'd3, 0, 16'h2000);
    // R8: renumber root to 255, then wrap below bus is 0
    send(1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 32'h0001_02FF, 16'h2000);
    send(0, 8'd255, 5'd0, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    send(0, 8'd0, 5'd2, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    send(0, 8'd0, 5'd0, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    // R8: forwarded write to 0x18 must not renumber
    send(1, 8'd0, 5'd0, 3'd0, 12'h018, 2'd2, 32'h07, 16'h2000);
    send(0, 8'd255, 5'd0, 3'd0, 12'h000, 2'd2, 0, 16'h2000);
    send(1, 8'd255, 5'd0, 3'd0, 12'h018, 2'd0, 32'h10, 16'h2000);
    idle_check();
    // random mix
    for (int i = 0; i < 600; i++) begin
      int bsel = $urandom_range(0, 3);
      logic [7:0] b = (bsel == 0) ? m_root : (bsel == 1) ? 8'(m_root + 1) :
                      (bsel == 2) ? 8'(m_root + 2) : 8'($urandom);
      logic [4:0] d = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0;
      logic [2:0] f = ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0;
      int osel = $urandom_range(0, 5);
      logic [11:0] o = (osel == 0) ? 12'h010 : (osel == 1) ? 12'h018 : 12'($urandom);
      logic [15:0] ls = 16'($urandom);
      if ($urandom_range(0, 1) == 1) ls[13] = 1'b1;
      send($urandom_range(0, 1) == 1, b, d, f, o, 2'($urandom), $urandom, ls);
      if ($urandom_range(0, 9) == 0) idle_check();
    end
    if (!summary_done) begin
      summary_done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule